// File: doc/BRIEF.md
# Hitless Reference Switch Sequencer

This block controls how a clock-cleaning loop locks again after it loses lock, for example when its input reference is swapped. It runs a fixed sequence. First the phase comparator is switched off and the loop filter is held in its narrow setting. Next, if build-out is enabled, the feedback divider is told to move its sampling edge by a whole number of oscillator cycles, so that feedback lines up with the new reference. The comparator is then switched back on. The block waits until the loop shows tight lock for a run of consecutive comparisons, lets a hold timer run out, and then returns the filter to the bandwidth the user chose. After that it can be triggered again.

The analog loop stays outside this block. It reports three things:
- a level that says lock is lost,
- a per-comparison strobe that is high when the edge error is inside the tight window,
- the measured phase offset between the new reference and the current feedback edge, as a signed fixed-point count of oscillator cycles.

The block drives three things:
- the comparator enable,
- the filter bandwidth select,
- a one-cycle edge-shift command carrying a signed whole-cycle step.

The qualifying run length and the hold time are parameters counted in sequencer clock ticks.

Top module: `hs_switch_seq`

## Requirements
- R1: After reset the block is unarmed. The comparator enable is 1, the bandwidth select follows the user mode bit, the shift command valid is 0 and the shift step is 0.
- R2: The block arms only after it has seen the lock-loss flag low on a clock edge. While it is unarmed, a high lock-loss flag has no effect: the comparator stays enabled and the bandwidth is not forced.
- R3: While armed, a high lock-loss flag on a clock edge starts the sequence. From the next cycle the comparator enable is 0 and the narrow bandwidth select is 1. This hold step lasts exactly one cycle.
- R4: With build-out enabled on the edge that ends the hold step, the next cycle carries the shift command: valid is 1 for exactly one cycle and the comparator stays disabled. The step equals the offset sampled on that edge, rounded to the nearest whole cycle. The offset is two's complement with FRAC_W fractional bits, and an exact half rounds toward positive infinity (1.5 gives 2, -1.5 gives -1).
- R5: With build-out disabled on that edge, no shift command is issued and the offset input is ignored. The step output is 0 whenever valid is 0, and the sequence goes straight to relock.
- R6: During relock, qualification and the hold timer, the comparator is enabled and the narrow bandwidth select is 1.
- R7: Lock qualifies once the tight-lock strobe has been high on LOCK_CYC consecutive edges in relock. Any edge with the strobe low resets the run to zero.
- R8: Qualification starts a hold timer of TIMER_CYC edges. Narrow bandwidth stays forced while it runs. When it expires, the bandwidth select returns to the user mode and the block is armed again. The lock-loss flag is ignored from the hold step until expiry.
- R9: When the user mode bit selects narrow (1), the bandwidth select output is 1 in every state.
- R10: After re-arming, a new lock-loss flag starts a new sequence. A flag that is already high on the expiry edge starts it one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lol_i | input | 1 | Lock-loss flag from the loop |
| tight_i | input | 1 | Per-comparison strobe: edge error inside the tight window |
| ofs_i | input | OFS_W | Signed phase offset in oscillator cycles, FRAC_W fractional bits |
| nbw_user_i | input | 1 | User bandwidth mode, 1 = narrow |
| pbo_en_i | input | 1 | Build-out enable |
| pd_en_o | output | 1 | Phase comparator enable |
| bw_narrow_o | output | 1 | Loop filter narrow bandwidth select |
| adj_valid_o | output | 1 | Feedback edge shift command valid |
| adj_step_o | output | OFS_W-FRAC_W+1 | Signed whole-cycle shift step |

## Verification
Two events can land on the same edge. The first case is the hold timer expiring while the lock-loss flag is already high: the directed sequence keeps the flag high through the whole relock. The expected result is one armed cycle with user bandwidth, then a new hold step. The second case is a tight-lock miss on the exact edge that would complete the qualifying run: the directed sequence places a miss after seven hits. The random phase keeps both overlaps occurring often, and a cycle-by-cycle reference model in the bench compares every output on every cycle.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_HOLD   = 3'd2,
    ST_BUILD  = 3'd3,
    ST_RELOCK = 3'd4,
    ST_TIMER  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/hs_round.sv
module hs_round #(
  parameter int OFS_W  = 10,
  parameter int FRAC_W = 4,
  localparam int STEP_W = OFS_W - FRAC_W + 1
) (
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [STEP_W-1:0] step_o
);
  generate
    if (FRAC_W == 0) begin : g_int
      assign step_o = {ofs_i[OFS_W-1], ofs_i};
    end else begin : g_frac
      localparam int HALF_I = 1 << (FRAC_W - 1);
      localparam logic [OFS_W:0] HALF = HALF_I[OFS_W:0];
      logic [OFS_W:0] sum;
      // add one half then floor: nearest edge, ties upward
      assign sum    = {ofs_i[OFS_W-1], ofs_i} + HALF;
      assign step_o = sum[OFS_W:FRAC_W];
    end
  endgenerate
endmodule

// File: rtl/hs_lock_qual.sv
module hs_lock_qual #(
  parameter int LOCK_CYC = 8,
  localparam int CNT_W = $clog2(LOCK_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tight_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && tight_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || !tight_i)   cnt_q <= '0;
    else if (done_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R7
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R7
  run_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_o || en_i && cnt_q == '0 && LOCK_CYC == 1);
endmodule

// File: rtl/hs_hold_timer.sv
module hs_hold_timer #(
  parameter int TIMER_CYC = 9,
  localparam int CNT_W = $clog2(TIMER_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMER_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R8
  timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R8
  timer_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);
endmodule

// File: rtl/hs_switch_seq.sv
module hs_switch_seq
  import hs_seq_pkg::*;
#(
  parameter int OFS_W     = 10,
  parameter int FRAC_W    = 4,
  parameter int LOCK_CYC  = 8,
  parameter int TIMER_CYC = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lol_i,
  input  logic                   tight_i,
  input  logic [OFS_W-1:0]       ofs_i,
  input  logic                   nbw_user_i,
  input  logic                   pbo_en_i,
  output logic                   pd_en_o,
  output logic                   bw_narrow_o,
  output logic                   adj_valid_o,
  output logic [OFS_W-FRAC_W:0]  adj_step_o
);
  localparam int STEP_W = OFS_W - FRAC_W + 1;

  seq_state_e        state_q, state_d;
  logic              qual_done, tmr_expire;
  logic [STEP_W-1:0] step_rnd;
  logic              adj_valid_q;
  logic [STEP_W-1:0] adj_step_q;
  logic              build_go;

  hs_round #(.OFS_W(OFS_W), .FRAC_W(FRAC_W)) u_round (
    .ofs_i  (ofs_i),
    .step_o (step_rnd)
  );

  hs_lock_qual #(.LOCK_CYC(LOCK_CYC)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (state_q == ST_RELOCK),
    .tight_i (tight_i),
    .done_o  (qual_done)
  );

  hs_hold_timer #(.TIMER_CYC(TIMER_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_TIMER),
    .expire_o (tmr_expire)
  );

  assign build_go = (state_q == ST_HOLD) && pbo_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (!lol_i)     state_d = ST_ARMED;
      ST_ARMED:  if (lol_i)      state_d = ST_HOLD;
      ST_HOLD:                   state_d = pbo_en_i ? ST_BUILD : ST_RELOCK;
      ST_BUILD:                  state_d = ST_RELOCK;
      ST_RELOCK: if (qual_done)  state_d = ST_TIMER;
      ST_TIMER:  if (tmr_expire) state_d = ST_ARMED;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      adj_valid_q <= 1'b0;
      adj_step_q  <= '0;
    end else begin
      state_q     <= state_d;
      adj_valid_q <= build_go;
      adj_step_q  <= build_go ? step_rnd : '0;
    end
  end

  assign pd_en_o     = !(state_q == ST_HOLD || state_q == ST_BUILD);
  assign bw_narrow_o = nbw_user_i || !(state_q == ST_IDLE || state_q == ST_ARMED);
  assign adj_valid_o = adj_valid_q;
  assign adj_step_o  = adj_step_q;

  // R2
  unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && lol_i) |=> pd_en_o && state_q == ST_IDLE);
  // R3
  trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && lol_i) |=> !pd_en_o && bw_narrow_o);
  // R4
  adj_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_valid_o |=> !adj_valid_o);
  // R4
  adj_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_valid_o |-> !pd_en_o && bw_narrow_o);
  // R5
  adj_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_valid_o |-> $past(pbo_en_i));
  // R5
  step_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adj_valid_o |-> adj_step_o == '0);
  // R7
  miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELOCK && !tight_i) |=> state_q == ST_RELOCK);
  // R9
  user_nbw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbw_user_i |-> bw_narrow_o);
endmodule

// File: tb/hs_switch_seq_tb_top.sv
module hs_switch_seq_tb_top;
  localparam int OFS_W = 10, FRAC_W = 4, LOCK_CYC = 8, TIMER_CYC = 9;
  localparam int STEP_W = OFS_W - FRAC_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lol = 1'b1, tight = 1'b0, nbw = 1'b0, pbo = 1'b0;
  logic [OFS_W-1:0] ofs = '0;
  logic pd_en, bw_nar, adj_v;
  logic signed [STEP_W-1:0] adj_step;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hs_switch_seq #(.OFS_W(OFS_W), .FRAC_W(FRAC_W), .LOCK_CYC(LOCK_CYC),
                  .TIMER_CYC(TIMER_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lol_i(lol), .tight_i(tight), .ofs_i(ofs),
    .nbw_user_i(nbw), .pbo_en_i(pbo), .pd_en_o(pd_en), .bw_narrow_o(bw_nar),
    .adj_valid_o(adj_v), .adj_step_o(adj_step));

  // reference model: 0 idle 1 armed 2 hold 3 build 4 relock 5 timer
  int ms = 0, mq = 0, mt = 0, mstep = 0;

  function automatic int rnd_step(input logic [OFS_W-1:0] v);
    int s;
    s = int'($signed(v)) + (1 << (FRAC_W - 1));
    return s >>> FRAC_W;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0; mq <= 0; mt <= 0; mstep <= 0;
    end else begin
      case (ms)
        0: if (!lol) ms <= 1;
        1: if (lol) ms <= 2;
        2: if (pbo) begin ms <= 3; mstep <= rnd_step(ofs); end else ms <= 4;
        3: ms <= 4;
        4: if (!tight) mq <= 0;
           else if (mq == LOCK_CYC - 1) begin mq <= 0; ms <= 5; end
           else mq <= mq + 1;
        default: if (mt == TIMER_CYC - 1) begin mt <= 0; ms <= 1; end
                 else mt <= mt + 1;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 pd_en", int'(pd_en), (ms == 2 || ms == 3) ? 0 : 1);
      chk("R9 bw_narrow", int'(bw_nar), (nbw || ms >= 2) ? 1 : 0);
      chk("R4 adj_valid", int'(adj_v), (ms == 3) ? 1 : 0);
      chk("R5 adj_step", int'(adj_step), (ms == 3) ? mstep : 0);
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 pd_en", int'(pd_en), 1);
    chk("R1 bw", int'(bw_nar), 0);
    chk("R1 adj_valid", int'(adj_v), 0);
    repeat (4) tick();
    chk("R2 unarmed pd_en", int'(pd_en), 1);
    chk("R2 unarmed bw", int'(bw_nar), 0);
    lol = 1'b0; tick();
    lol = 1'b1; tick();
    chk("R3 pd_en", int'(pd_en), 0);
    chk("R3 bw", int'(bw_nar), 1);
    pbo = 1'b0; ofs = 10'sd24; tick();
    chk("R5 adj_valid", int'(adj_v), 0);
    chk("R5 step", int'(adj_step), 0);
    chk("R6 pd_en", int'(pd_en), 1);
    tight = 1'b1; repeat (7) tick();
    tight = 1'b0; tick();
    tight = 1'b1; repeat (7) tick();
    chk("R7 still narrow", int'(bw_nar), 1);
    tick();
    repeat (TIMER_CYC - 1) tick();
    chk("R8 timer narrow", int'(bw_nar), 1);
    tick();
    chk("R8 wide back", int'(bw_nar), 0);
    chk("R8 pd_en", int'(pd_en), 1);
    tick();
    chk("R10 retrigger", int'(pd_en), 0);
    pbo = 1'b1; ofs = 10'sd24; tick();
    chk("R4 adj_valid", int'(adj_v), 1);
    chk("R4 step +1.5", int'(adj_step), 2);
    chk("R4 pd_en", int'(pd_en), 0);
    ofs = '0; tick();
    chk("R4 pulse end", int'(adj_v), 0);
    lol = 1'b0; repeat (LOCK_CYC + TIMER_CYC) tick();
    lol = 1'b1; tick();
    ofs = -10'sd24; tick();
    chk("R4 step -1.5", int'(adj_step), -1);
    lol = 1'b0; repeat (LOCK_CYC + TIMER_CYC + 1) tick();
    nbw = 1'b1; tick();
    chk("R9 user narrow", int'(bw_nar), 1);
    for (int i = 0; i < 4000; i++) begin
      lol   = ($urandom % 12) == 0;
      tight = ($urandom % 7) != 0;
      pbo   = $urandom % 2;
      ofs   = OFS_W'($urandom);
      if (($urandom % 32) == 0) nbw = ~nbw;
      tick();
    end
    summary();
  end
endmodule